// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block keeps track of a single exclusive reservation for one processor thread. It has two states, Open and Exclusive. A load-exclusive request takes the block into Exclusive and records the accessed address, rounded down to the access size, together with that size. A store-exclusive request returns a pass or fail verdict and a write enable for the memory write. Every store-exclusive, and every clear request, takes the block back to Open.

Software calls the clear request, or issues a store-exclusive to a scratch address, when the running thread changes. After that, any store-exclusive that has no fresh load-exclusive before it fails, and the thread must repeat its load/store sequence. A snoop port reports stores made by other agents. When such a store falls inside the reserved granule, the reservation is cancelled.

The parameter `TAG_CHECK` sets how strict a store-exclusive is. With 0, a store-exclusive passes whenever the block is in Exclusive. With 1, its aligned address and its size must also match the recorded reservation.

Top module: `resv_monitor`

## Requirements
- R1: While `rst_n` is low, the block is in Open and `replyValid`, `replyFail` and `wrEn` are 0.
- R2: A load-exclusive without a clear or store-exclusive in the same cycle puts the block in Exclusive. It records `reqAddr` with its low `reqSize` bits cleared, and also records `reqSize`. `reqSize` is log2 of the byte count: 0 means 1 byte and 3 means 8 bytes.
- R3: A store-exclusive that passes gives `replyFail`=0 and `wrEn`=1. It passes when the block is in Exclusive and, if `TAG_CHECK`=1, the tag also matches.
- R4: A store-exclusive made while the block is in Open gives `replyFail`=1 and `wrEn`=0.
- R5: Every store-exclusive, whether it passes or fails and whatever its address, leaves the block in Open. A second store-exclusive with no load-exclusive in between therefore fails.
- R6: A clear request leaves the block in Open. A clear request in the same cycle as a load-exclusive takes priority over it.
- R7: A new load-exclusive replaces the earlier reservation, both its address and its size.
- R8: With `TAG_CHECK`=1, a store-exclusive fails if its aligned address or its size differs from the recorded tag. With `TAG_CHECK`=0, address and size have no effect on the verdict.
- R9: A snoop store whose address, rounded down to the reserved size, equals the tag moves the block to Open. A snoop outside the granule leaves the reservation in place.
- R10: `replyValid` is 1 in exactly the cycle that follows a store-exclusive request pulse. The verdict on that request is held in registers and is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldReq | input | 1 | Load-exclusive request pulse |
| stReq | input | 1 | Store-exclusive request pulse |
| clrReq | input | 1 | Clear request (used on context switch) |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqSize | input | 2 | log2 of the access size in bytes |
| snoopValid | input | 1 | A store by another agent was observed |
| snoopAddr | input | ADDR_W | Address of the observed store |
| replyValid | output | 1 | Store-exclusive verdict valid |
| replyFail | output | 1 | 1 = store-exclusive failed, 0 = passed |
| wrEn | output | 1 | Permission for the memory write |

## Verification
The monitor state itself is not visible at the ports. It only shows up in the verdict of the next store-exclusive, one cycle after that request. If the state or the tag has gone wrong, the bench sees a flipped `replyFail`/`wrEn` pair on that probe. The bench therefore follows every load, clear and snoop pattern with a store-exclusive. It runs two instances side by side, one with tag checking and one without, so that an error in the tag shows up as a difference between the two that a model in the bench predicts.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic {MON_OPEN = 1'b0, MON_EXCL = 1'b1} monState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureTag;
    logic replyValid;
    logic replyPass;
  } resvStrobes_t;
endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter bit TAG_CHECK = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ldReq,
  input  logic         stReq,
  input  logic         clrReq,
  input  logic         stTagOk,
  input  logic         snoopHit,
  output resvStrobes_t strobes,
  output monState_e    monState
);
  monState_e nextState;
  logic      tagGate;

  generate
    if (TAG_CHECK) begin : g_tagged
      assign tagGate = stTagOk;
    end else begin : g_untagged
      assign tagGate = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes.replyValid = stReq;
    strobes.replyPass  = stReq && (monState == MON_EXCL) && tagGate;
    strobes.captureTag = ldReq && !clrReq && !stReq;
    nextState          = monState;
    if (clrReq || stReq) begin
      nextState = MON_OPEN;
    end else if (ldReq) begin
      nextState = MON_EXCL;
    end else if (snoopHit && monState == MON_EXCL) begin
      nextState = MON_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) monState <= MON_OPEN;
    else        monState <= nextState;
  end
endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  resvStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              stTagOk,
  output logic              snoopHit,
  output logic              replyValid,
  output logic              replyFail,
  output logic              wrEn
);
  logic [ADDR_W-1:0] tagAddr;
  logic [SIZE_W-1:0] tagSize;
  logic [ADDR_W-1:0] reqAligned;
  logic [ADDR_W-1:0] snoopAligned;

  function automatic logic [ADDR_W-1:0] alignDown(input logic [ADDR_W-1:0] a,
                                                  input logic [SIZE_W-1:0] sz);
    logic [ADDR_W-1:0] lowMask;
    lowMask = (ADDR_W'(1) << sz) - ADDR_W'(1);
    return a & ~lowMask;
  endfunction

  assign reqAligned   = alignDown(reqAddr, reqSize);
  assign snoopAligned = alignDown(snoopAddr, tagSize);
  assign stTagOk      = (reqAligned == tagAddr) && (reqSize == tagSize);
  assign snoopHit     = snoopValid && (snoopAligned == tagAddr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tagAddr <= '0;
      tagSize <= '0;
    end else if (strobes.captureTag) begin
      tagAddr <= reqAligned;
      tagSize <= reqSize;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replyValid <= 1'b0;
      replyFail  <= 1'b0;
      wrEn       <= 1'b0;
    end else begin
      replyValid <= strobes.replyValid;
      replyFail  <= strobes.replyValid && !strobes.replyPass;
      wrEn       <= strobes.replyPass;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit TAG_CHECK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldReq,
  input  logic              stReq,
  input  logic              clrReq,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              replyValid,
  output logic              replyFail,
  output logic              wrEn
);
  localparam int SIZE_W = 2;

  resvStrobes_t strobes;
  monState_e    monState;
  logic         stTagOk;
  logic         snoopHit;

  resv_ctrl #(.TAG_CHECK(TAG_CHECK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ldReq(ldReq), .stReq(stReq), .clrReq(clrReq),
    .stTagOk(stTagOk), .snoopHit(snoopHit), .strobes(strobes), .monState(monState)
  );

  resv_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .reqAddr(reqAddr), .reqSize(reqSize),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .stTagOk(stTagOk),
    .snoopHit(snoopHit), .replyValid(replyValid), .replyFail(replyFail), .wrEn(wrEn)
  );
endmodule

// File: rtl/resv_monitor_checker.sv
module resv_monitor_checker
  import resv_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      ldReq,
  input logic      stReq,
  input logic      clrReq,
  input monState_e monState,
  input logic      replyValid,
  input logic      replyFail,
  input logic      wrEn
);
  // R1
  a_r1_reset_open: assert property (@(posedge clk)
    !rst_n |-> (monState == MON_OPEN) && !replyValid && !replyFail && !wrEn);

  // R10
  a_r10_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
    stReq |=> replyValid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !stReq |=> !replyValid && !wrEn && !replyFail);

  // R5
  a_r5_store_closes: assert property (@(posedge clk) disable iff (!rst_n)
    stReq |=> monState == MON_OPEN);

  // R6
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clrReq |=> monState == MON_OPEN);

  // R2
  a_r2_load_reserves: assert property (@(posedge clk) disable iff (!rst_n)
    (ldReq && !clrReq && !stReq) |=> monState == MON_EXCL);

  // R4
  a_r4_open_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (stReq && monState == MON_OPEN) |=> replyFail && !wrEn);

  // R3
  a_r3_pass_needs_excl: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> !replyFail && $past(monState) == MON_EXCL);
endmodule

bind resv_monitor resv_monitor_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ldReq(ldReq), .stReq(stReq), .clrReq(clrReq),
  .monState(monState), .replyValid(replyValid), .replyFail(replyFail), .wrEn(wrEn)
);

// File: tb/resv_monitor_test.sv
`timescale 1ns/1ps
module resv_monitor_test;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ldReq = 0, stReq = 0, clrReq = 0, snoopValid = 0;
  logic [AW-1:0] reqAddr = '0, snoopAddr = '0;
  logic [1:0]    reqSize = '0;
  logic          rvT, rfT, weT, rvN, rfN, weN;

  int  vectors = 0;
  int  fails = 0;
  bit  done = 0;

  // reference state
  bit            mExcl = 0;
  logic [AW-1:0] mTag = '0;
  logic [1:0]    mSize = '0;

  always #10 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .TAG_CHECK(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ldReq(ldReq), .stReq(stReq), .clrReq(clrReq),
    .reqAddr(reqAddr), .reqSize(reqSize), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .replyValid(rvT), .replyFail(rfT), .wrEn(weT)
  );

  resv_monitor #(.ADDR_W(AW), .TAG_CHECK(1'b0)) uutNoTag (
    .clk(clk), .rst_n(rst_n), .ldReq(ldReq), .stReq(stReq), .clrReq(clrReq),
    .reqAddr(reqAddr), .reqSize(reqSize), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .replyValid(rvN), .replyFail(rfN), .wrEn(weN)
  );

  function automatic logic [AW-1:0] rnd(input logic [AW-1:0] a, input logic [1:0] s);
    return (a >> s) << s;
  endfunction

  task automatic compare(input string req, input logic [5:0] act, input logic [5:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {rvT,rfT,weT,rvN,rfN,weN} actual %b expected %b", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, check after the next negedge
  task automatic step(input string req, input bit ld, input bit st, input bit clr,
                      input logic [AW-1:0] a, input logic [1:0] s,
                      input bit snV, input logic [AW-1:0] snA);
    bit passT, passN;
    logic [5:0] exp;
    ldReq = ld; stReq = st; clrReq = clr; reqAddr = a; reqSize = s;
    snoopValid = snV; snoopAddr = snA;
    passT = st && mExcl && (rnd(a, s) == mTag) && (s == mSize);
    passN = st && mExcl;
    exp = {st, st && !passT, passT, st, st && !passN, passN};
    if (clr || st) mExcl = 0;
    else if (ld) begin mExcl = 1; mTag = rnd(a, s); mSize = s; end
    else if (snV && mExcl && rnd(snA, mSize) == mTag) mExcl = 0;
    @(negedge clk);
    compare(req, {rvT, rfT, weT, rvN, rfN, weN}, exp);
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, '0, 2'd0, 0, '0);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    compare("R1", {rvT, rfT, weT, rvN, rfN, weN}, 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R4: first store after reset fails (Open)
    step("R4", 0, 1, 0, 6'd8, 2'd2, 0, '0);
    idle("R10");

    // R2 R3 R8 R10: load then store sweep over address/size
    for (int la = 0; la < 16; la++)
      for (int ls = 0; ls < 4; ls++)
        for (int sa = 0; sa < 16; sa++)
          for (int ss = 0; ss < 4; ss++) begin
            step("R2", 1, 0, 0, AW'(la), 2'(ls), 0, '0);
            step("R8", 0, 1, 0, AW'(sa), 2'(ss), 0, '0);
          end

    // R9: snoop sweep against each reservation
    for (int la = 0; la < 16; la++)
      for (int ls = 0; ls < 4; ls++)
        for (int sn = 0; sn < 16; sn++) begin
          step("R9", 1, 0, 0, AW'(la), 2'(ls), 0, '0);
          step("R9", 0, 0, 0, '0, 2'd0, 1, AW'(sn));
          step("R9", 0, 1, 0, AW'(la), 2'(ls), 0, '0);
        end

    // R5: second store without reload fails
    step("R5", 1, 0, 0, 6'd20, 2'd2, 0, '0);
    step("R3", 0, 1, 0, 6'd20, 2'd2, 0, '0);
    step("R5", 0, 1, 0, 6'd20, 2'd2, 0, '0);
    // R5: dummy store to another address then real store fails
    step("R5", 1, 0, 0, 6'd40, 2'd3, 0, '0);
    step("R5", 0, 1, 0, 6'd63, 2'd0, 0, '0);
    step("R5", 0, 1, 0, 6'd40, 2'd3, 0, '0);
    // R6: clear then store fails
    step("R6", 1, 0, 0, 6'd12, 2'd1, 0, '0);
    step("R6", 0, 0, 1, '0, 2'd0, 0, '0);
    step("R6", 0, 1, 0, 6'd12, 2'd1, 0, '0);
    // R6: clear beats same-cycle load
    step("R6", 1, 0, 1, 6'd12, 2'd1, 0, '0);
    step("R6", 0, 1, 0, 6'd12, 2'd1, 0, '0);
    // R7: later load replaces tag
    step("R7", 1, 0, 0, 6'd4, 2'd2, 0, '0);
    step("R7", 1, 0, 0, 6'd32, 2'd0, 0, '0);
    step("R7", 0, 1, 0, 6'd4, 2'd2, 0, '0);
    step("R7", 1, 0, 0, 6'd4, 2'd2, 0, '0);
    step("R7", 1, 0, 0, 6'd32, 2'd0, 0, '0);
    step("R7", 0, 1, 0, 6'd32, 2'd0, 0, '0);
    // R10: back-to-back stores, then quiet
    step("R10", 0, 1, 0, 6'd1, 2'd0, 0, '0);
    step("R10", 0, 1, 0, 6'd1, 2'd0, 0, '0);
    idle("R10");
    idle("R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule